// File: doc/BRIEF.md
# Receive-Enable Delay Position Normalizer

The block holds one receive-enable delay position as four nested fields. From coarsest to finest they are a cycle count, a half-phase, a tap and a pico-step, and a separate two-bit preamble value sits beside them. A calibration sequencer moves the position with single step commands or sets it with an absolute load. After every command the block carries or borrows between the fields until each one is back inside its range, so the sequencer can treat the position as one number written in mixed radix.

The tap and pico radices depend on a speed-mode input, which is sampled when a command is accepted. Normalization runs as a small state machine with the states IDLE, PICO, TAP and PHASE. IDLE goes to PICO when a command is accepted. Each of PICO, TAP and PHASE loops on itself while its field is out of range, doing one carry or borrow per cycle, and otherwise moves on: PICO to TAP, TAP to PHASE, and PHASE back to IDLE. The normalized fields are packed into a 32-bit group timing word, and the cycle count goes out on its own 4-bit output.

Top module: `rcv_dly_norm`

## Requirements
- R1: After reset all fields and the preamble are zero, `grp_word` and `cyc_val` are 0, `done` is 1 and `err` is 0.
- R2: Commands are coded on `cmd` as: 0 load, 1 full backstep, 2 half backstep, 3 quarter step, 4 quarter backstep, 5 smallest step, 6 add to tap, 7 no change (normalize only). Load sets cycle, half-phase, tap and pico from `ld_cyc`, `ld_ph`, `ld_tap` and `ld_pico`, sets the preamble from `ld_pre`, and the result is then normalized.
- R3: `grp_word` carries tap in bits 31:28, pico in 26:24, half-phase in 23:22 and preamble in 21:20. All other bits are 0. `cyc_val` carries the low 4 bits of the cycle field.
- R4: With `speed_fast`=1 the tap radix is 9 and the pico radix is 8. With `speed_fast`=0 they are 12 and 1. The mode is sampled on the cycle a command is accepted and applies to that command and its normalization.
- R5: Normalization first brings pico into [0, pico radix), then tap into [0, tap radix), then half-phase into [0, 4), by carrying into or borrowing from the next coarser field.
- R6: Each tap carry adds 2 to the half-phase and each tap borrow subtracts 2. Each half-phase carry or borrow moves the cycle field by one.
- R7: A quarter step adds floor(tap radix / 2) to the tap. When the tap radix is odd it also adds floor(pico radix / 2) to the pico. A quarter backstep subtracts the same amounts.
- R8: A full backstep subtracts 1 from the cycle field, a half backstep subtracts 2 from the half-phase, and a smallest step adds 1 to the pico.
- R9: Add to tap adds the signed 5-bit `tap_add` to the tap field.
- R10: If the cycle field is outside 0..15 when normalization finishes, `err` goes to 1 and stays at 1 until reset.
- R11: `done` falls on the clock edge that accepts a command and rises again when normalization has finished. A command presented while `done` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_fast | input | 1 | Speed mode, selects the radices |
| cmd_valid | input | 1 | Command strobe, accepted while `done` is 1 |
| cmd | input | 3 | Command code |
| ld_cyc | input | 4 | Load value for the cycle field |
| ld_ph | input | 2 | Load value for the half-phase field |
| ld_tap | input | 4 | Load value for the tap field |
| ld_pico | input | 3 | Load value for the pico field |
| ld_pre | input | 2 | Load value for the preamble |
| tap_add | input | 5 | Signed amount for the add-to-tap command |
| done | output | 1 | The position is normalized and a command can be accepted |
| err | output | 1 | Sticky flag: the cycle field left its range |
| grp_word | output | 32 | Packed group timing word |
| cyc_val | output | 4 | Cycle field |

## Verification
The bench goes after carries that ripple through every level at once. One smallest step from the top of each range has to end with tap, pico and half-phase all at zero and the cycle one higher; a design that normalized out of order, or stopped after one pass, would leave a field out of range. It also checks the odd-radix quarter step, where a design without the pico share would lose four pico-steps, and borrows below zero, where an unsigned field would wrap to a large value. A change of speed mode makes a valid slow-mode tap overflow in fast mode, which catches radices that are not sampled at acceptance. Cycle overflow and underflow must set a flag that stays set, and a command sent while the block is busy must leave no trace.

// File: rtl/rcv_dly_pkg.sv
package rcv_dly_pkg;

    localparam int ACC_W = 8;

    typedef enum logic [2:0] {
        CMD_LOAD       = 3'd0,
        CMD_FULL_BACK  = 3'd1,
        CMD_HALF_BACK  = 3'd2,
        CMD_QTR_STEP   = 3'd3,
        CMD_QTR_BACK   = 3'd4,
        CMD_SMALL_STEP = 3'd5,
        CMD_ADD_TAP    = 3'd6,
        CMD_NONE       = 3'd7
    } dly_cmd_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_PICO,
        S_TAP,
        S_PHASE
    } norm_state_e;

    typedef struct packed {
        logic signed [ACC_W-1:0] cyc;
        logic signed [ACC_W-1:0] ph;
        logic signed [ACC_W-1:0] tap;
        logic signed [ACC_W-1:0] pico;
    } dly_pos_t;

endpackage

// File: rtl/rcv_dly_radix.sv
module rcv_dly_radix
    import rcv_dly_pkg::*;
#(
    parameter int FAST_TAP  = 9,
    parameter int SLOW_TAP  = 12,
    parameter int FAST_PICO = 8,
    parameter int SLOW_PICO = 1
) (
    input  logic                    fast,
    output logic signed [ACC_W-1:0] tap_rad,
    output logic signed [ACC_W-1:0] pico_rad
);
    localparam logic signed [ACC_W-1:0] FT = ACC_W'(FAST_TAP);
    localparam logic signed [ACC_W-1:0] ST = ACC_W'(SLOW_TAP);
    localparam logic signed [ACC_W-1:0] FP = ACC_W'(FAST_PICO);
    localparam logic signed [ACC_W-1:0] SP = ACC_W'(SLOW_PICO);

    always_comb begin
        tap_rad  = fast ? FT : ST;
        pico_rad = fast ? FP : SP;
    end
endmodule

// File: rtl/rcv_dly_step.sv
module rcv_dly_step
    import rcv_dly_pkg::*;
#(
    parameter int CYC_W  = 4,
    parameter int PH_W   = 2,
    parameter int TAP_W  = 4,
    parameter int PICO_W = 3,
    parameter int ADD_W  = 5
) (
    input  dly_cmd_e                cmd,
    input  dly_pos_t                pos_i,
    input  logic signed [ACC_W-1:0] tap_rad,
    input  logic signed [ACC_W-1:0] pico_rad,
    input  logic [CYC_W-1:0]        ld_cyc,
    input  logic [PH_W-1:0]         ld_ph,
    input  logic [TAP_W-1:0]        ld_tap,
    input  logic [PICO_W-1:0]       ld_pico,
    input  logic signed [ADD_W-1:0] tap_add,
    output dly_pos_t                pos_o
);
    localparam logic signed [ACC_W-1:0] ONE  = ACC_W'(1);
    localparam logic signed [ACC_W-1:0] TWO  = ACC_W'(2);
    localparam logic signed [ACC_W-1:0] ZERO = '0;

    logic signed [ACC_W-1:0] q_tap;
    logic signed [ACC_W-1:0] q_pico;

    always_comb begin
        q_tap  = tap_rad >>> 1;
        q_pico = tap_rad[0] ? (pico_rad >>> 1) : ZERO;
        pos_o  = pos_i;
        unique case (cmd)
            CMD_LOAD: begin
                pos_o.cyc  = ACC_W'(ld_cyc);
                pos_o.ph   = ACC_W'(ld_ph);
                pos_o.tap  = ACC_W'(ld_tap);
                pos_o.pico = ACC_W'(ld_pico);
            end
            CMD_FULL_BACK:  pos_o.cyc  = pos_i.cyc - ONE;
            CMD_HALF_BACK:  pos_o.ph   = pos_i.ph - TWO;
            CMD_QTR_STEP: begin
                pos_o.tap  = pos_i.tap + q_tap;
                pos_o.pico = pos_i.pico + q_pico;
            end
            CMD_QTR_BACK: begin
                pos_o.tap  = pos_i.tap - q_tap;
                pos_o.pico = pos_i.pico - q_pico;
            end
            CMD_SMALL_STEP: pos_o.pico = pos_i.pico + ONE;
            CMD_ADD_TAP:    pos_o.tap  = pos_i.tap + ACC_W'(tap_add);
            CMD_NONE:       pos_o      = pos_i;
        endcase
    end
endmodule

// File: rtl/rcv_dly_pack.sv
module rcv_dly_pack #(
    parameter int CYC_W  = 4,
    parameter int PH_W   = 2,
    parameter int TAP_W  = 4,
    parameter int PICO_W = 3,
    parameter int PRE_W  = 2,
    parameter int WORD_W = 32
) (
    input  logic [TAP_W-1:0]  tap,
    input  logic [PICO_W-1:0] pico,
    input  logic [PH_W-1:0]   ph,
    input  logic [PRE_W-1:0]  pre,
    input  logic [CYC_W-1:0]  cyc,
    output logic [WORD_W-1:0] word,
    output logic [CYC_W-1:0]  cyc_o
);
    localparam int TAP_LSB  = 28;
    localparam int PICO_LSB = 24;
    localparam int PH_LSB   = 22;
    localparam int PRE_LSB  = 20;

    always_comb begin
        word = '0;
        word[TAP_LSB  +: TAP_W]  = tap;
        word[PICO_LSB +: PICO_W] = pico;
        word[PH_LSB   +: PH_W]   = ph;
        word[PRE_LSB  +: PRE_W]  = pre;
        cyc_o = cyc;
    end
endmodule

// File: rtl/rcv_dly_norm.sv
module rcv_dly_norm
    import rcv_dly_pkg::*;
#(
    parameter int CYC_W     = 4,
    parameter int PH_W      = 2,
    parameter int TAP_W     = 4,
    parameter int PICO_W    = 3,
    parameter int PRE_W     = 2,
    parameter int ADD_W     = 5,
    parameter int WORD_W    = 32,
    parameter int FAST_TAP  = 9,
    parameter int SLOW_TAP  = 12,
    parameter int FAST_PICO = 8,
    parameter int SLOW_PICO = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    speed_fast,
    input  logic                    cmd_valid,
    input  logic [2:0]              cmd,
    input  logic [CYC_W-1:0]        ld_cyc,
    input  logic [PH_W-1:0]         ld_ph,
    input  logic [TAP_W-1:0]        ld_tap,
    input  logic [PICO_W-1:0]       ld_pico,
    input  logic [PRE_W-1:0]        ld_pre,
    input  logic signed [ADD_W-1:0] tap_add,
    output logic                    done,
    output logic                    err,
    output logic [WORD_W-1:0]       grp_word,
    output logic [CYC_W-1:0]        cyc_val
);
    localparam logic signed [ACC_W-1:0] ZERO   = '0;
    localparam logic signed [ACC_W-1:0] ONE    = ACC_W'(1);
    localparam logic signed [ACC_W-1:0] TWO    = ACC_W'(2);
    localparam logic signed [ACC_W-1:0] PH_RAD = ACC_W'(2 ** PH_W);
    localparam logic signed [ACC_W-1:0] CYC_HI = ACC_W'(2 ** CYC_W - 1);
    localparam logic signed [ACC_W-1:0] FP_S   = ACC_W'(FAST_PICO);
    localparam logic signed [ACC_W-1:0] SP_S   = ACC_W'(SLOW_PICO);
    localparam logic signed [ACC_W-1:0] FT_S   = ACC_W'(FAST_TAP);
    localparam logic signed [ACC_W-1:0] ST_S   = ACC_W'(SLOW_TAP);

    norm_state_e state_q, state_d;
    dly_pos_t    pos_q, pos_d, step_pos;
    logic [PRE_W-1:0] pre_q, pre_d;
    logic        mode_q, mode_d, mode_sel;
    logic        err_q, err_d;
    logic signed [ACC_W-1:0] tap_rad, pico_rad;
    dly_cmd_e    cmd_e;

    assign cmd_e    = dly_cmd_e'(cmd);
    assign mode_sel = (state_q == S_IDLE) ? speed_fast : mode_q;

    rcv_dly_radix #(
        .FAST_TAP (FAST_TAP),
        .SLOW_TAP (SLOW_TAP),
        .FAST_PICO(FAST_PICO),
        .SLOW_PICO(SLOW_PICO)
    ) radix_i (
        .fast    (mode_sel),
        .tap_rad (tap_rad),
        .pico_rad(pico_rad)
    );

    rcv_dly_step #(
        .CYC_W (CYC_W),
        .PH_W  (PH_W),
        .TAP_W (TAP_W),
        .PICO_W(PICO_W),
        .ADD_W (ADD_W)
    ) step_i (
        .cmd     (cmd_e),
        .pos_i   (pos_q),
        .tap_rad (tap_rad),
        .pico_rad(pico_rad),
        .ld_cyc  (ld_cyc),
        .ld_ph   (ld_ph),
        .ld_tap  (ld_tap),
        .ld_pico (ld_pico),
        .tap_add (tap_add),
        .pos_o   (step_pos)
    );

    rcv_dly_pack #(
        .CYC_W (CYC_W),
        .PH_W  (PH_W),
        .TAP_W (TAP_W),
        .PICO_W(PICO_W),
        .PRE_W (PRE_W),
        .WORD_W(WORD_W)
    ) pack_i (
        .tap  (pos_q.tap[TAP_W-1:0]),
        .pico (pos_q.pico[PICO_W-1:0]),
        .ph   (pos_q.ph[PH_W-1:0]),
        .pre  (pre_q),
        .cyc  (pos_q.cyc[CYC_W-1:0]),
        .word (grp_word),
        .cyc_o(cyc_val)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q  <= '0;
            pre_q  <= '0;
            mode_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            pos_q  <= pos_d;
            pre_q  <= pre_d;
            mode_q <= mode_d;
            err_q  <= err_d;
        end
    end

    // Next state and datapath
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        pre_d   = pre_q;
        mode_d  = mode_q;
        err_d   = err_q;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid) begin
                    pos_d   = step_pos;
                    mode_d  = speed_fast;
                    if (cmd_e == CMD_LOAD) pre_d = ld_pre;
                    state_d = S_PICO;
                end
            end
            S_PICO: begin
                if (pos_q.pico >= pico_rad) begin
                    pos_d.pico = pos_q.pico - pico_rad;
                    pos_d.tap  = pos_q.tap + ONE;
                end else if (pos_q.pico < ZERO) begin
                    pos_d.pico = pos_q.pico + pico_rad;
                    pos_d.tap  = pos_q.tap - ONE;
                end else begin
                    state_d = S_TAP;
                end
            end
            S_TAP: begin
                if (pos_q.tap >= tap_rad) begin
                    pos_d.tap = pos_q.tap - tap_rad;
                    pos_d.ph  = pos_q.ph + TWO;
                end else if (pos_q.tap < ZERO) begin
                    pos_d.tap = pos_q.tap + tap_rad;
                    pos_d.ph  = pos_q.ph - TWO;
                end else begin
                    state_d = S_PHASE;
                end
            end
            S_PHASE: begin
                if (pos_q.ph >= PH_RAD) begin
                    pos_d.ph  = pos_q.ph - PH_RAD;
                    pos_d.cyc = pos_q.cyc + ONE;
                end else if (pos_q.ph < ZERO) begin
                    pos_d.ph  = pos_q.ph + PH_RAD;
                    pos_d.cyc = pos_q.cyc - ONE;
                end else begin
                    if (pos_q.cyc < ZERO || pos_q.cyc > CYC_HI) err_d = 1'b1;
                    state_d = S_IDLE;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        done = (state_q == S_IDLE);
        err  = err_q;
    end

    p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cmd_valid) |=> !done);

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cmd_valid) |=> ($stable(grp_word) && $stable(cyc_val)));

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    p_err_at_finish_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

    p_cyc_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (pos_q.cyc >= ZERO && pos_q.cyc <= CYC_HI));

    p_norm_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pos_q.pico >= ZERO && pos_q.pico < (mode_q ? FP_S : SP_S) &&
                  pos_q.tap >= ZERO && pos_q.tap < (mode_q ? FT_S : ST_S) &&
                  pos_q.ph >= ZERO && pos_q.ph < PH_RAD));

endmodule

// File: tb/rcv_dly_norm_tb_top.sv
`timescale 1ns/1ps
module rcv_dly_norm_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        speed_fast = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd = 3'd7;
    logic [3:0]  ld_cyc = '0;
    logic [1:0]  ld_ph = '0;
    logic [3:0]  ld_tap = '0;
    logic [2:0]  ld_pico = '0;
    logic [1:0]  ld_pre = '0;
    logic signed [4:0] tap_add = '0;
    logic        done, err;
    logic [31:0] grp_word;
    logic [3:0]  cyc_val;

    int n_run = 0;
    int n_fail = 0;

    // reference model state
    int m_c, m_ph, m_t, m_p, m_pre, m_err;

    always #2.5 clk = ~clk;

    rcv_dly_norm dut_i (
        .clk(clk), .rst_n(rst_n), .speed_fast(speed_fast),
        .cmd_valid(cmd_valid), .cmd(cmd), .ld_cyc(ld_cyc), .ld_ph(ld_ph),
        .ld_tap(ld_tap), .ld_pico(ld_pico), .ld_pre(ld_pre), .tap_add(tap_add),
        .done(done), .err(err), .grp_word(grp_word), .cyc_val(cyc_val)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_word();
        logic [31:0] w;
        w = '0;
        w[31:28] = 4'(m_t);
        w[26:24] = 3'(m_p);
        w[23:22] = 2'(m_ph);
        w[21:20] = 2'(m_pre);
        return w;
    endfunction

    task automatic model_apply(input int c, input bit fast, input int lc, input int lph,
                               input int lt, input int lp, input int lpre, input int add);
        int tr, pr;
        tr = fast ? 9 : 12;
        pr = fast ? 8 : 1;
        case (c)
            0: begin m_c = lc; m_ph = lph; m_t = lt; m_p = lp; m_pre = lpre; end
            1: m_c--;
            2: m_ph -= 2;
            3: begin m_t += tr / 2; m_p += (tr % 2) * (pr / 2); end
            4: begin m_t -= tr / 2; m_p -= (tr % 2) * (pr / 2); end
            5: m_p++;
            6: m_t += add;
            default: ;
        endcase
        while (m_p >= pr) begin m_t++; m_p -= pr; end
        while (m_p < 0)   begin m_t--; m_p += pr; end
        while (m_t >= tr) begin m_ph += 2; m_t -= tr; end
        while (m_t < 0)   begin m_ph -= 2; m_t += tr; end
        while (m_ph >= 4) begin m_c++; m_ph -= 4; end
        while (m_ph < 0)  begin m_c--; m_ph += 4; end
        if (m_c < 0 || m_c > 15) m_err = 1;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!done && guard < 100) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic issue(input int c, input bit fast, input int lc = 0, input int lph = 0,
                         input int lt = 0, input int lp = 0, input int lpre = 0,
                         input int add = 0);
        @(negedge clk);
        speed_fast = fast;
        cmd = 3'(c);
        ld_cyc = 4'(lc); ld_ph = 2'(lph); ld_tap = 4'(lt);
        ld_pico = 3'(lp); ld_pre = 2'(lpre); tap_add = 5'(add);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        model_apply(c, fast, lc, lph, lt, lp, lpre, add);
        wait_done();
    endtask

    task automatic chk_model(input string req);
        chk(req, grp_word, model_word());
        chk(req, {28'd0, cyc_val}, 32'(m_c & 15));
        chk(req, {31'd0, err}, 32'(m_err));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        m_c = 0; m_ph = 0; m_t = 0; m_p = 0; m_pre = 0; m_err = 0;
    endtask

    task automatic t_reset();
        chk("R1 word", grp_word, 32'd0);
        chk("R1 cyc", {28'd0, cyc_val}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd1);
        chk("R1 err", {31'd0, err}, 32'd0);
    endtask

    task automatic t_load();
        issue(0, 1'b1, 5, 2, 3, 4, 1);
        chk("R3 packing", grp_word, 32'h3490_0000);
        chk("R3 cycle", {28'd0, cyc_val}, 32'd5);
        chk_model("R2 load");
    endtask

    task automatic t_radix();
        issue(0, 1'b0, 2, 0, 10, 3, 0);   // slow: pico radix 1, tap 13 carries
        chk_model("R4 slow load");
        issue(0, 1'b0, 2, 0, 10, 0, 0);
        chk_model("R4 slow tap 10 valid");
        issue(7, 1'b1);                   // fast: tap 10 now overflows
        chk_model("R4 mode switch");
    endtask

    task automatic t_quarter();
        issue(0, 1'b1, 3, 0, 0, 6, 0);
        issue(3, 1'b1);
        chk_model("R7 quarter step odd radix");
        issue(4, 1'b1);
        chk_model("R7 quarter backstep odd radix");
        issue(0, 1'b0, 3, 0, 0, 0, 0);
        issue(4, 1'b0);
        chk_model("R7 quarter backstep borrow slow");
        issue(3, 1'b0);
        chk_model("R7 quarter step slow");
    endtask

    task automatic t_cascade();
        issue(0, 1'b1, 2, 2, 8, 7, 0);
        issue(5, 1'b1);
        chk("R5 full cascade word", grp_word, 32'd0);
        chk("R5 full cascade cyc", {28'd0, cyc_val}, 32'd3);
        chk_model("R8 smallest step");
    endtask

    task automatic t_back();
        issue(0, 1'b0, 3, 0, 5, 0, 2);
        issue(2, 1'b0);
        chk_model("R6 half backstep borrow");
        issue(1, 1'b0);
        chk_model("R8 full backstep");
        issue(2, 1'b0);
        chk_model("R8 half backstep");
    endtask

    task automatic t_addtap();
        issue(0, 1'b0, 4, 0, 11, 0, 0);
        issue(6, 1'b0, 0, 0, 0, 0, 0, 15);
        chk_model("R9 add positive");
        issue(6, 1'b0, 0, 0, 0, 0, 0, -16);
        chk_model("R9 add negative");
        issue(6, 1'b1, 0, 0, 0, 0, 0, 13);
        chk_model("R6 two tap carries");
    endtask

    task automatic t_busy();
        issue(0, 1'b1, 6, 0, 2, 1, 0);
        @(negedge clk);
        speed_fast = 1'b1; cmd = 3'd1; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R11 done low after accept", {31'd0, done}, 32'd0);
        model_apply(1, 1'b1, 0, 0, 0, 0, 0, 0);
        cmd = 3'd5; cmd_valid = 1'b1;    // presented while busy
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_done();
        chk("R11 done back high", {31'd0, done}, 32'd1);
        chk_model("R11 busy command ignored");
    endtask

    task automatic t_err();
        do_reset();
        issue(0, 1'b0, 0, 0, 0, 0, 0);
        issue(1, 1'b0);
        chk("R10 underflow err", {31'd0, err}, 32'd1);
        issue(0, 1'b0, 4, 0, 0, 0, 0);
        chk("R10 err sticky", {31'd0, err}, 32'd1);
        chk("R10 load after err", {28'd0, cyc_val}, 32'd4);
        do_reset();
        issue(0, 1'b0, 15, 2, 11, 0, 0);
        chk("R10 no err at top", {31'd0, err}, 32'd0);
        issue(5, 1'b0);
        chk("R10 overflow err", {31'd0, err}, 32'd1);
    endtask

    initial begin
        m_c = 0; m_ph = 0; m_t = 0; m_p = 0; m_pre = 0; m_err = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_radix();
        t_quarter();
        t_cascade();
        t_back();
        t_addtap();
        t_busy();
        t_err();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule